// File: doc/BRIEF.md
# Registered Mode-Selected Integer ALU

This block is a 32-bit arithmetic-logic unit for an integer datapath. A 4-bit mode code selects one operation on two operands: signed or unsigned addition, signed or unsigned subtraction, one of four bitwise functions, or a signed or unsigned less-than comparison. The block returns a result word together with a carry flag and an overflow flag.

The arithmetic is built as a ripple chain of identical 1-bit slices. Each slice holds a full adder and the bitwise functions, and a per-slice selector picks one of them. Shared control logic sets the operand inversion and the carry into bit 0. Logic at the top of the chain forms overflow, the less-than bit, the NOR inversion and the flag masking. All three outputs are captured in one output register, so a mode and its operands presented in one cycle appear at the outputs after the next rising clock edge.

Top module: `alu32_core`

## Requirements
- R1: Mode 0 (signed add) and mode 1 (unsigned add) return (A + B) mod 2^32. The carry flag is the carry out of bit 31.
- R2: Mode 2 (signed subtract) and mode 3 (unsigned subtract) return A + ~B + 1 mod 2^32. The carry flag is the raw carry out of that sum, so it is 1 when no borrow occurs.
- R3: In modes 0 and 2 the overflow flag is 1 exactly when both addends of the effective sum (A and B, or A and ~B) have the same sign and the result's sign differs from that sign.
- R4: Modes 1 and 3 never set the overflow flag.
- R5: Mode 4 returns A AND B, mode 5 returns A OR B, and mode 6 returns A XOR B.
- R6: Mode 7 returns NOR(A, B), that is (A OR B) XOR all-ones.
- R7: Mode 10 returns 1 when A is less than B as signed two's-complement values, and 0 otherwise. The decision is the sign of A − B XOR the subtraction overflow, so it stays correct when A − B overflows.
- R8: Mode 11 returns 1 when A is less than B as unsigned values, that is when A − B gives no carry out, and 0 otherwise.
- R9: Modes 4, 5, 6, 7, 10 and 11 drive the carry flag and the overflow flag to 0.
- R10: Mode codes 8, 9 and 12 to 15 drive the result, the carry flag and the overflow flag to 0.
- R11: The outputs show the operation sampled at the previous rising clock edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset; clears the outputs |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| mode | input | 4 | Operation select code |
| result | output | 32 | Registered result word |
| carry_out | output | 1 | Registered carry flag |
| overflow | output | 1 | Registered signed-overflow flag |

## Verification
The only internal state is the output register. Everything in front of it is control decode and the carry chain, so any fault shows up at the ports in the cycle after the faulty operation is presented. A wrong inversion or carry-in in the decode corrupts every subtract and compare. A wrong carry link between slices appears only for operand pairs whose carries pass through that bit, so the stimulus mixes long carry runs, sign-boundary operands and random words across all sixteen codes. A wrong flag mask shows up as a flag that is set in a mode that must hold it at 0.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    typedef enum logic [3:0] {
        MD_ADD  = 4'd0,
        MD_ADDU = 4'd1,
        MD_SUB  = 4'd2,
        MD_SUBU = 4'd3,
        MD_AND  = 4'd4,
        MD_OR   = 4'd5,
        MD_XOR  = 4'd6,
        MD_NOR  = 4'd7,
        MD_SLT  = 4'd10,
        MD_SLTU = 4'd11
    } mode_e;

    typedef enum logic [1:0] {
        PICK_SUM = 2'd0,
        PICK_AND = 2'd1,
        PICK_OR  = 2'd2,
        PICK_XOR = 2'd3
    } pick_e;

    typedef struct packed {
        logic  known;      // mode code is defined
        logic  b_inv;      // invert B into the chain
        logic  c_first;    // carry into slice 0
        pick_e pick;       // per-slice output choice
        logic  flip;       // invert the word (NOR)
        logic  arith_s;    // report signed overflow
        logic  carry_en;   // expose carry out
        logic  less_sel;   // result is the less-than bit
        logic  less_s;     // signed comparison
    } ctrl_t;

endpackage

// File: rtl/alu32_decode.sv
module alu32_decode
    import alu32_pkg::*;
(
    input  logic [3:0] mode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        ctrl.pick = PICK_SUM;
        case (mode)
            MD_ADD: begin
                ctrl.known = 1'b1; ctrl.arith_s = 1'b1; ctrl.carry_en = 1'b1;
            end
            MD_ADDU: begin
                ctrl.known = 1'b1; ctrl.carry_en = 1'b1;
            end
            MD_SUB: begin
                ctrl.known = 1'b1; ctrl.b_inv = 1'b1; ctrl.c_first = 1'b1;
                ctrl.arith_s = 1'b1; ctrl.carry_en = 1'b1;
            end
            MD_SUBU: begin
                ctrl.known = 1'b1; ctrl.b_inv = 1'b1; ctrl.c_first = 1'b1;
                ctrl.carry_en = 1'b1;
            end
            MD_AND: begin
                ctrl.known = 1'b1; ctrl.pick = PICK_AND;
            end
            MD_OR: begin
                ctrl.known = 1'b1; ctrl.pick = PICK_OR;
            end
            MD_XOR: begin
                ctrl.known = 1'b1; ctrl.pick = PICK_XOR;
            end
            MD_NOR: begin
                ctrl.known = 1'b1; ctrl.pick = PICK_OR; ctrl.flip = 1'b1;
            end
            MD_SLT: begin
                ctrl.known = 1'b1; ctrl.b_inv = 1'b1; ctrl.c_first = 1'b1;
                ctrl.less_sel = 1'b1; ctrl.less_s = 1'b1;
            end
            MD_SLTU: begin
                ctrl.known = 1'b1; ctrl.b_inv = 1'b1; ctrl.c_first = 1'b1;
                ctrl.less_sel = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/alu32_slice.sv
module alu32_slice
    import alu32_pkg::*;
(
    input  logic  a,
    input  logic  b,
    input  logic  b_inv,
    input  logic  cin,
    input  pick_e pick,
    output logic  res,
    output logic  cout
);

    logic bb;
    logic half;

    always_comb begin
        bb   = b ^ b_inv;
        half = a ^ bb;
        cout = (a & bb) | (cin & half);
        unique case (pick)
            PICK_SUM: res = half ^ cin;
            PICK_AND: res = a & bb;
            PICK_OR:  res = a | bb;
            PICK_XOR: res = half;
        endcase
    end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       mode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);

    localparam int MSB = WIDTH - 1;

    ctrl_t            ctrl;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] word;
    logic             ovf_raw;
    logic             less;
    logic [WIDTH-1:0] res_next;
    logic             carry_next;
    logic             ovf_next;

    alu32_decode u_decode (
        .mode (mode),
        .ctrl (ctrl)
    );

    assign chain[0] = ctrl.c_first;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu32_slice u_slice (
            .a     (op_a[i]),
            .b     (op_b[i]),
            .b_inv (ctrl.b_inv),
            .cin   (chain[i]),
            .pick  (ctrl.pick),
            .res   (word[i]),
            .cout  (chain[i+1])
        );
    end

    always_comb begin
        ovf_raw = chain[MSB] ^ chain[WIDTH];
        less    = ctrl.less_s ? (word[MSB] ^ ovf_raw) : ~chain[WIDTH];
        if (!ctrl.known) begin
            res_next = '0;
        end else if (ctrl.less_sel) begin
            res_next = {{(WIDTH-1){1'b0}}, less};
        end else begin
            res_next = word ^ {WIDTH{ctrl.flip}};
        end
        carry_next = ctrl.carry_en & chain[WIDTH];
        ovf_next   = ctrl.arith_s & ovf_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            result    <= res_next;
            carry_out <= carry_next;
            overflow  <= ovf_next;
        end
    end

endmodule

// File: rtl/alu32_core_chk.sv
module alu32_core_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       mode,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             overflow
);

    localparam int MSB = WIDTH - 1;

    // R4
    unsigned_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd1 || mode == 4'd3) |=> !overflow);

    // R9
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11}) |=> (!carry_out && !overflow));

    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode inside {4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15})
        |=> (result == '0 && !carry_out && !overflow));

    // R7 R8
    less_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd10 || mode == 4'd11) |=> (result[WIDTH-1:1] == '0));

    // R5
    and_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd4) |=> (result == ($past(op_a) & $past(op_b))));

    // R3
    mixed_sign_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd0 && op_a[MSB] != op_b[MSB]) |=> !overflow);

endmodule

bind alu32_core alu32_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .mode      (mode),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
);

// File: tb/alu32_core_bench.sv
`timescale 1ns/1ps
module alu32_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  mode = '0;
    logic [31:0] result;
    logic        carry_out;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu32_core u_alu32_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a      (op_a),
        .op_b      (op_b),
        .mode      (mode),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0, 4'd1: return "R1/R3/R4";
            4'd2, 4'd3: return "R2/R3/R4";
            4'd4, 4'd5, 4'd6: return "R5/R9";
            4'd7: return "R6/R9";
            4'd10: return "R7/R9";
            4'd11: return "R8/R9";
            default: return "R10";
        endcase
    endfunction

    // behavioural reference model
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m,
                         output logic [31:0] r, output logic c, output logic v);
        longint unsigned ua = a;
        longint unsigned ub = b;
        longint unsigned t;
        longint sa = $signed(a);
        longint sb = $signed(b);
        r = '0; c = 1'b0; v = 1'b0;
        case (m)
            4'd0, 4'd1: begin
                t = ua + ub;
                r = t[31:0]; c = t[32];
                if (m == 4'd0) v = (sa + sb > 64'sd2147483647) || (sa + sb < -64'sd2147483648);
            end
            4'd2, 4'd3: begin
                t = ua + (~ub & 64'hFFFF_FFFF) + 1;
                r = t[31:0]; c = t[32];
                if (m == 4'd2) v = (sa - sb > 64'sd2147483647) || (sa - sb < -64'sd2147483648);
            end
            4'd4: r = a & b;
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            4'd7: r = ~(a | b);
            4'd10: r = (sa < sb) ? 32'd1 : 32'd0;
            4'd11: r = (ua < ub) ? 32'd1 : 32'd0;
            default: ;
        endcase
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
        logic [31:0] er;
        logic ec, ev;
        model(a, b, m, er, ec, ev);
        @(negedge clk);
        op_a = a; op_b = b; mode = m;
        @(negedge clk);
        checks++;
        if (result !== er || carry_out !== ec || overflow !== ev) begin
            errors++;
            $display("FAIL %s R11 mode=%0d a=%h b=%h: actual r=%h c=%b v=%b expected r=%h c=%b v=%b",
                     tag_of(m), m, a, b, result, carry_out, overflow, er, ec, ev);
        end
    endtask

    task automatic check_zero(input string what);
        checks++;
        if (result !== '0 || carry_out !== 1'b0 || overflow !== 1'b0) begin
            errors++;
            $display("FAIL R11 %s: actual r=%h c=%b v=%b expected all zero",
                     what, result, carry_out, overflow);
        end
    endtask

    initial begin
        #20000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; mode = 4'd0;
        repeat (3) @(negedge clk);
        check_zero("reset state");            // R11
        rst_n = 1'b1;

        apply(32'd7, 32'd3, 4'd0);                 // R1
        apply(32'h7FFF_FFFF, 32'd1, 4'd0);         // R3 positive overflow
        apply(32'h8000_0000, 32'h8000_0000, 4'd0); // R3 carry and overflow
        apply(32'hFFFF_FFFF, 32'd1, 4'd1);         // R1 carry, R4 none
        apply(32'h7FFF_FFFF, 32'd1, 4'd1);         // R4
        apply(32'd0, 32'd1, 4'd2);                 // R2 borrow
        apply(32'd5, 32'd5, 4'd2);                 // R2 carry 1
        apply(32'h8000_0000, 32'd1, 4'd2);         // R3 negative overflow
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd2); // R3
        apply(32'h8000_0000, 32'd1, 4'd3);         // R4
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'd4); // R5
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'd5); // R5
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'd6); // R5
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'd7); // R6
        apply(32'd0, 32'd0, 4'd7);                 // R6
        apply(32'h8000_0000, 32'd1, 4'd10);        // R7 overflowing compare
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd10);// R7
        apply(32'd4, 32'd4, 4'd10);                // R7 equal
        apply(32'd1, 32'h8000_0000, 4'd11);        // R8
        apply(32'hFFFF_FFFF, 32'd0, 4'd11);        // R8
        for (int m = 8; m < 16; m++) begin         // R10
            if (m != 10 && m != 11) apply(32'hFFFF_FFFF, 32'h1234_5678, m[3:0]);
        end
        for (int i = 0; i < 400; i++) begin
            apply($urandom, $urandom, 4'($urandom_range(0, 15)));
        end

        @(negedge clk);                            // R11 reset mid-run
        op_a = 32'hFFFF_FFFF; op_b = 32'd1; mode = 4'd0;
        rst_n = 1'b0;
        #1;
        check_zero("asynchronous reset");
        @(negedge clk);
        check_zero("held in reset");
        rst_n = 1'b1;
        apply(32'd2, 32'd9, 4'd3);                 // R2 after reset

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule